// File: doc/BRIEF.md
# Masked Scalar Single-Precision Multiply Unit

This unit sits beside a 128-bit vector register file. It multiplies the lowest 32-bit single-precision lane of two operands and builds a full 128-bit destination word from the product and the surrounding lanes. Two operand formats are supported. In the three-operand format the multiplicand and the upper lanes come from a first source. In the legacy two-operand format the old destination doubles as the first source. In the three-operand format a one-bit write mask can keep or clear the low lane instead of writing the product.

The rounding mode is picked per operation. A static override is honoured only when it is flagged valid and the second operand came from a register. In every other case the global mode field applies. Five exception flags come out with each result. The result and the flags are registered, so they appear one clock after the operands are presented. Denormal operands and denormal results are handled exactly, with no flush to zero.

Top module: `scalar_fmul_unit`

## Requirements
- R1: Bits 31:0 of the result are the IEEE single-precision product of the two low operands, rounded in the selected mode. The mode encodings are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R2: The mode is `rm_static_i` when `rm_static_vld_i` and `src2_is_reg_i` are both 1. Otherwise it is `rm_global_i`.
- R3: With `three_op_i`=1 the multiplicand is `src1_i[31:0]`, and result bits 127:32 equal `src1_i[127:32]`.
- R4: With `three_op_i`=0 the multiplicand is `dst_old_i[31:0]` and result bits 127:32 equal `dst_old_i[127:32]`. In this format `src1_i` and all mask inputs have no effect.
- R5: With `three_op_i`=1, `mask_en_i`=1, `mask_bit_i`=0 and `mask_zero_i`=0, result bits 31:0 equal `dst_old_i[31:0]`. With the mask disabled or `mask_bit_i`=1, the product is written.
- R6: With `three_op_i`=1, `mask_en_i`=1, `mask_bit_i`=0 and `mask_zero_i`=1, result bits 31:0 are zero.
- R7: When the low lane is kept or zeroed by the mask, all five flags are 0.
- R8: Special operands are handled as follows, with flags bit 0 = invalid. Zero times infinity gives 0x7FC00000 and sets invalid. A NaN operand is returned with bit 22 set, and the first operand wins when both are NaN. A signalling NaN sets invalid; a quiet NaN sets no flag. Zero and infinity results carry the XOR of the operand signs. Invalid is never raised together with overflow, underflow or inexact.
- R9: On overflow (flags bit 2), the result goes to infinity when rounding to nearest or when the rounding direction matches the sign. Otherwise it goes to the largest finite magnitude 0x7F7FFFFF with the sign. The inexact flag (bit 4) is also set.
- R10: Denormal operands are multiplied exactly. Flags bit 1 is set when either operand is denormal and neither is a NaN.
- R11: A result whose exponent before rounding lies below the normal range is rounded at the denormal position, and may round up to the smallest normal. Flags bit 3 (underflow) is set only when such a result is also inexact.
- R12: Flags bit 4 (inexact) is set whenever the delivered value differs from the exact product.
- R13: Result and flags appear one clock edge after the inputs. While reset is low both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src1_i | input | 128 | First source (three-operand format) |
| src2_i | input | 128 | Second source; only bits 31:0 are used |
| dst_old_i | input | 128 | Current destination value |
| three_op_i | input | 1 | 1 = three-operand format, 0 = legacy two-operand format |
| mask_en_i | input | 1 | Write mask in force (three-operand format only) |
| mask_bit_i | input | 1 | Mask bit for the low lane |
| mask_zero_i | input | 1 | 1 = zero a masked-off lane, 0 = keep it |
| rm_static_i | input | 2 | Per-operation rounding override |
| rm_static_vld_i | input | 1 | Override requested |
| rm_global_i | input | 2 | Global rounding mode |
| src2_is_reg_i | input | 1 | Second source came from a register |
| dst_o | output | 128 | Assembled destination |
| flags_o | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
The bench sweeps many normal-range operand pairs through all four rounding modes, both through the global field and through the override. It compares each result against products formed in double-precision real arithmetic, so a rounding increment on the wrong condition or a missed carry into the exponent shows up as a one-ulp error. All sixteen combinations of format and mask controls are swept with distinct lane contents. A wrong lane source or a mask that leaks into the legacy format would therefore put the wrong word into some lane. Directed cases cover the paths where a design most often slips:
- a halfway tie at the denormal boundary, where a wrong choice either rounds away from even or fails to promote into the smallest normal;
- a product far below the denormal range, where a lost sticky bit would hide the directed-rounding result 0x00000001;
- overflow in each mode and sign, where a wrong saturation choice returns infinity instead of 0x7F7FFFFF;
- NaN ordering and quieting, where the wrong operand wins or a signalling NaN passes through unquieted.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fflags_t;

  localparam int FLAG_W = $bits(fflags_t);

endpackage

// File: rtl/fmul_rm_sel.sv
module fmul_rm_sel
  import fmul_pkg::*;
(
  input  logic [1:0] rm_static_i,
  input  logic       rm_static_vld_i,
  input  logic [1:0] rm_global_i,
  input  logic       src2_is_reg_i,
  output rmode_e     rm_o
);

  logic use_static;

  assign use_static = rm_static_vld_i & src2_is_reg_i;
  assign rm_o       = rmode_e'(use_static ? rm_static_i : rm_global_i);

endmodule

// File: rtl/fmul_lead_one.sv
module fmul_lead_one #(
  parameter int W = 48
) (
  input  logic [W-1:0]         vec_i,
  output logic [$clog2(W)-1:0] pos_o
);

  localparam int LW = $clog2(W);

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = LW'(i);
    end
  end

endmodule

// File: rtl/fmul_core.sv
module fmul_core
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  rmode_e                rm_i,
  output logic [EXP_W+FRAC_W:0] res_o,
  output fflags_t               flags_o
);

  localparam int MW   = FRAC_W + 1;
  localparam int PW   = 2 * MW;
  localparam int LW   = $clog2(PW);
  localparam int SW   = EXP_W + LW + 3;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int W    = 1 + EXP_W + FRAC_W;

  localparam logic [W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // operand fields and classes
  logic              sa, sb, sr;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero, a_den, b_den;

  assign {sa, ea, fa} = a_i;
  assign {sb, eb, fb} = b_i;
  assign sr     = sa ^ sb;
  assign a_nan  = (ea == '1) && (fa != '0);
  assign b_nan  = (eb == '1) && (fb != '0);
  assign a_snan = a_nan && !fa[FRAC_W-1];
  assign b_snan = b_nan && !fb[FRAC_W-1];
  assign a_inf  = (ea == '1) && (fa == '0);
  assign b_inf  = (eb == '1) && (fb == '0);
  assign a_zero = (ea == '0) && (fa == '0);
  assign b_zero = (eb == '0) && (fb == '0);
  assign a_den  = (ea == '0) && (fa != '0);
  assign b_den  = (eb == '0) && (fb != '0);

  // significand product
  logic [MW-1:0] ma, mb;
  logic [PW-1:0] prod;
  logic [LW-1:0] lpos;

  assign ma   = {|ea, fa};
  assign mb   = {|eb, fb};
  assign prod = {{MW{1'b0}}, ma} * {{MW{1'b0}}, mb};

  fmul_lead_one #(.W(PW)) u_lead (
    .vec_i (prod),
    .pos_o (lpos)
  );

  // exponent of the normalised product
  logic [SW-1:0] eae, ebe, be, rs;
  logic [LW-1:0] nshift;
  logic [PW-1:0] pn;
  logic          tiny;

  assign eae    = {{(SW-EXP_W){1'b0}}, (ea == '0) ? EXP_W'(1) : ea};
  assign ebe    = {{(SW-EXP_W){1'b0}}, (eb == '0) ? EXP_W'(1) : eb};
  assign be     = {{(SW-LW){1'b0}}, lpos} + eae + ebe - SW'(BIAS + 2 * FRAC_W);
  assign nshift = LW'(PW - 1) - lpos;
  assign pn     = prod << nshift;
  assign tiny   = be[SW-1] || (be == '0);
  assign rs     = SW'(1) - be;

  // denormal alignment, rounding, exponent adjust
  logic [PW-1:0] pd;
  logic          lost, grd, stk, inc, ovf, sat_inf;
  logic [MW-1:0] mrnd, mant;
  logic [MW:0]   msum;
  logic [SW-1:0] be_n, bef;

  always_comb begin
    pd   = pn;
    lost = 1'b0;
    be_n = be;
    if (tiny) begin
      be_n = SW'(1);
      if (rs >= SW'(PW)) begin
        pd   = '0;
        lost = |pn;
      end else begin
        pd   = pn >> rs;
        lost = |(pn << (SW'(PW) - rs));
      end
    end
    mrnd = pd[PW-1 -: MW];
    grd  = pd[PW-1-MW];
    stk  = (|pd[PW-2-MW:0]) | lost;
    unique case (rm_i)
      RM_NEAR: inc = grd & (stk | mrnd[0]);
      RM_DOWN: inc = (grd | stk) & sr;
      RM_UP:   inc = (grd | stk) & ~sr;
      default: inc = 1'b0;
    endcase
    msum = {1'b0, mrnd} + (MW+1)'(inc);
    if (msum[MW]) begin
      mant = msum[MW:1];
      bef  = be_n + SW'(1);
    end else begin
      mant = msum[MW-1:0];
      bef  = be_n;
    end
    ovf     = !bef[SW-1] && (bef >= SW'(EMAX));
    sat_inf = (rm_i == RM_NEAR) || ((rm_i == RM_DOWN) && sr) || ((rm_i == RM_UP) && !sr);
  end

  // special-case priority and final packing
  always_comb begin
    flags_o = '0;
    res_o   = '0;
    if (a_nan || b_nan) begin
      flags_o.invalid = a_snan | b_snan;
      if (a_nan) res_o = a_i | (W'(1) << (FRAC_W - 1));
      else       res_o = b_i | (W'(1) << (FRAC_W - 1));
    end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
      flags_o.invalid = 1'b1;
      res_o           = DEF_NAN;
    end else if (a_inf || b_inf) begin
      flags_o.denormal = a_den | b_den;
      res_o            = {sr, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (a_zero || b_zero) begin
      flags_o.denormal = a_den | b_den;
      res_o            = {sr, {(W-1){1'b0}}};
    end else begin
      flags_o.denormal = a_den | b_den;
      flags_o.inexact  = grd | stk | ovf;
      flags_o.underflow = tiny & (grd | stk);
      flags_o.overflow = ovf;
      if (ovf) begin
        res_o = sat_inf ? {sr, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                        : {sr, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end else begin
        res_o = {sr, mant[MW-1] ? bef[EXP_W-1:0] : {EXP_W{1'b0}}, mant[FRAC_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/fmul_lane_asm.sv
module fmul_lane_asm
  import fmul_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int LANE = 32
) (
  input  logic            three_op_i,
  input  logic            mask_en_i,
  input  logic            mask_bit_i,
  input  logic            mask_zero_i,
  input  logic [VLEN-1:0] src1_i,
  input  logic [VLEN-1:0] dst_old_i,
  input  logic [LANE-1:0] prod_i,
  input  fflags_t         flags_i,
  output logic [VLEN-1:0] dst_o,
  output fflags_t         flags_o
);

  localparam int LANES = VLEN / LANE;

  logic lane_off;

  assign lane_off = three_op_i & mask_en_i & ~mask_bit_i;

  always_comb begin
    flags_o = flags_i;
    dst_o[LANE-1:0] = prod_i;
    if (lane_off) begin
      flags_o         = '0;
      dst_o[LANE-1:0] = mask_zero_i ? '0 : dst_old_i[LANE-1:0];
    end
  end

  for (genvar l = 1; l < LANES; l++) begin : g_upper
    assign dst_o[l*LANE +: LANE] = three_op_i ? src1_i[l*LANE +: LANE]
                                              : dst_old_i[l*LANE +: LANE];
  end

endmodule

// File: rtl/scalar_fmul_unit.sv
module scalar_fmul_unit
  import fmul_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VLEN-1:0]   src1_i,
  input  logic [VLEN-1:0]   src2_i,
  input  logic [VLEN-1:0]   dst_old_i,
  input  logic              three_op_i,
  input  logic              mask_en_i,
  input  logic              mask_bit_i,
  input  logic              mask_zero_i,
  input  logic [1:0]        rm_static_i,
  input  logic              rm_static_vld_i,
  input  logic [1:0]        rm_global_i,
  input  logic              src2_is_reg_i,
  output logic [VLEN-1:0]   dst_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int LANE = 1 + EXP_W + FRAC_W;

  rmode_e          rm;
  logic [LANE-1:0] opa, prod;
  fflags_t         core_flags, flags_d;
  logic [VLEN-1:0] dst_d;

  fmul_rm_sel u_rm (
    .rm_static_i     (rm_static_i),
    .rm_static_vld_i (rm_static_vld_i),
    .rm_global_i     (rm_global_i),
    .src2_is_reg_i   (src2_is_reg_i),
    .rm_o            (rm)
  );

  assign opa = three_op_i ? src1_i[LANE-1:0] : dst_old_i[LANE-1:0];

  fmul_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
    .a_i     (opa),
    .b_i     (src2_i[LANE-1:0]),
    .rm_i    (rm),
    .res_o   (prod),
    .flags_o (core_flags)
  );

  fmul_lane_asm #(.VLEN(VLEN), .LANE(LANE)) u_asm (
    .three_op_i  (three_op_i),
    .mask_en_i   (mask_en_i),
    .mask_bit_i  (mask_bit_i),
    .mask_zero_i (mask_zero_i),
    .src1_i      (src1_i),
    .dst_old_i   (dst_old_i),
    .prod_i      (prod),
    .flags_i     (core_flags),
    .dst_o       (dst_d),
    .flags_o     (flags_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_o   <= '0;
      flags_o <= '0;
    end else begin
      dst_o   <= dst_d;
      flags_o <= flags_d;
    end
  end

endmodule

// File: rtl/scalar_fmul_unit_chk.sv
module scalar_fmul_unit_chk #(
  parameter int VLEN = 128,
  parameter int LANE = 32,
  parameter int FW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [VLEN-1:0] src1_i,
  input logic [VLEN-1:0] dst_old_i,
  input logic            three_op_i,
  input logic            mask_en_i,
  input logic            mask_bit_i,
  input logic            mask_zero_i,
  input logic [VLEN-1:0] dst_o,
  input logic [FW-1:0]   flags_o
);

  p_upper_src1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    three_op_i |=> dst_o[VLEN-1:LANE] == $past(src1_i[VLEN-1:LANE]));

  p_upper_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !three_op_i |=> dst_o[VLEN-1:LANE] == $past(dst_old_i[VLEN-1:LANE]));

  p_merge_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (three_op_i && mask_en_i && !mask_bit_i && !mask_zero_i)
      |=> dst_o[LANE-1:0] == $past(dst_old_i[LANE-1:0]));

  p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (three_op_i && mask_en_i && !mask_bit_i && mask_zero_i) |=> dst_o[LANE-1:0] == '0);

  p_quiet_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (three_op_i && mask_en_i && !mask_bit_i) |=> flags_o == '0);

  p_invalid_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[0] |-> !flags_o[2] && !flags_o[3] && !flags_o[4]);

  p_ovf_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[2] |-> flags_o[4]);

  p_unf_inexact_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[3] |-> flags_o[4]);

endmodule

bind scalar_fmul_unit scalar_fmul_unit_chk #(.VLEN(VLEN), .LANE(LANE), .FW(fmul_pkg::FLAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src1_i      (src1_i),
  .dst_old_i   (dst_old_i),
  .three_op_i  (three_op_i),
  .mask_en_i   (mask_en_i),
  .mask_bit_i  (mask_bit_i),
  .mask_zero_i (mask_zero_i),
  .dst_o       (dst_o),
  .flags_o     (flags_o)
);

// File: tb/sim_scalar_fmul_unit.sv
module sim_scalar_fmul_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] src1, src2, dold;
  logic         three_op, men, mbit, mzero, rmsv, s2reg;
  logic [1:0]   rms, rmg;
  logic [127:0] dst;
  logic [4:0]   flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  scalar_fmul_unit u0 (
    .clk (clk), .rst_n (rst_n), .src1_i (src1), .src2_i (src2), .dst_old_i (dold),
    .three_op_i (three_op), .mask_en_i (men), .mask_bit_i (mbit), .mask_zero_i (mzero),
    .rm_static_i (rms), .rm_static_vld_i (rmsv), .rm_global_i (rmg),
    .src2_is_reg_i (s2reg), .dst_o (dst), .flags_o (flags)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic mul3(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm);
    three_op = 1'b1; men = 1'b0; mbit = 1'b0; mzero = 1'b0;
    src1 = {96'hA5A5_0000_1111_2222_3333_4444, a};
    src2 = {96'h0, b};
    rmg = rm; rmsv = 1'b0; s2reg = 1'b1;
    step();
  endtask

  task automatic dir(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] rm, input logic [31:0] er, input logic [4:0] ef);
    mul3(a, b, rm);
    chk({tag, " value"}, {96'h0, dst[31:0]}, {96'h0, er});
    chk({tag, " flags"}, {123'h0, flags}, {123'h0, ef});
  endtask

  function automatic logic [63:0] to_dbl(input logic [31:0] x);
    return {x[31], 11'(x[30:23]) + 11'd896, x[22:0], 29'b0};
  endfunction

  // reference rounding of an exact double product to single precision
  task automatic ref_mul(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                         output logic [31:0] r, output logic inx, output logic ok);
    real p;
    logic [63:0] pb;
    logic [24:0] m25;
    logic g, st, inc;
    int e;
    p   = $bitstoreal(to_dbl(a)) * $bitstoreal(to_dbl(b));
    pb  = $realtobits(p);
    e   = int'(pb[62:52]) - 896;
    m25 = {1'b0, 1'b1, pb[51:29]};
    g   = pb[28];
    st  = |pb[27:0];
    case (rm)
      2'b00:   inc = g & (st | m25[0]);
      2'b01:   inc = (g | st) & pb[63];
      2'b10:   inc = (g | st) & ~pb[63];
      default: inc = 1'b0;
    endcase
    m25 = m25 + 25'(inc);
    if (m25[24]) begin
      m25 = m25 >> 1;
      e   = e + 1;
    end
    r   = {pb[63], e[7:0], m25[22:0]};
    inx = g | st;
    ok  = (e >= 1) && (e <= 254);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, r, el;
    logic inx, ok;
    logic [1:0] rm;
    rst_n = 1'b0;
    src1 = '0; src2 = '0; dold = '0;
    three_op = 1'b1; men = 1'b0; mbit = 1'b0; mzero = 1'b0;
    rms = 2'b00; rmsv = 1'b0; rmg = 2'b00; s2reg = 1'b1;
    src1[31:0] = 32'h3F80_0000; src2[31:0] = 32'h4000_0000;
    repeat (3) @(negedge clk);
    chk("R13 reset dst", dst, '0);
    chk("R13 reset flags", {123'h0, flags}, '0);
    rst_n = 1'b1;
    step();

    // R13: one-cycle latency
    mul3(32'h3F80_0000, 32'h4000_0000, 2'b00);
    src2[31:0] = 32'h4040_0000;
    #1;
    chk("R13 holds before edge", {96'h0, dst[31:0]}, {96'h0, 32'h4000_0000});
    step();
    chk("R13 after edge", {96'h0, dst[31:0]}, {96'h0, 32'h4040_0000});

    // R1/R12: normal products in all modes against the real-number reference
    for (int i = 0; i < 1600; i++) begin
      logic [31:0] x, y;
      x = rnd(); y = rnd();
      a = {x[31], 8'(100 + (x[30:23] % 50)), x[22:0]};
      b = {y[31], 8'(100 + (y[30:23] % 50)), y[22:0]};
      if (i % 8 == 3) a[22:0] = '1;
      if (i % 8 == 5) b[22:0] = 23'h000001;
      rm = 2'(i);
      ref_mul(a, b, rm, r, inx, ok);
      if (i[2]) begin
        three_op = 1'b1; men = 1'b0;
        src1 = {96'h0, a}; src2 = {96'h0, b};
        rms = rm; rmsv = 1'b1; s2reg = 1'b1; rmg = ~rm;
        step();
      end else begin
        mul3(a, b, rm);
      end
      if (ok) begin
        chk(i[2] ? "R2 override product" : "R1 product", {96'h0, dst[31:0]}, {96'h0, r});
        chk("R12 inexact flag", {123'h0, flags}, {123'h0, inx, 4'b0});
      end
    end

    // R3..R6: sweep of format and mask controls
    for (int c = 0; c < 16; c++) begin
      three_op = c[0]; men = c[1]; mbit = c[2]; mzero = c[3];
      src1 = {96'h1111_2222_3333_4444_5555_6666, 32'h4080_0000};
      dold = {96'h9999_AAAA_BBBB_CCCC_DDDD_EEEE, 32'h3FC0_0000};
      src2 = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h4000_0000};
      rmg = 2'b00; rmsv = 1'b0; s2reg = 1'b1;
      step();
      if (!c[0]) el = 32'h4040_0000;
      else if (!c[1] || c[2]) el = 32'h4100_0000;
      else if (c[3]) el = 32'h0;
      else el = 32'h3FC0_0000;
      if (c[0]) chk("R3 upper lanes", dst, {src1[127:32], el});
      else      chk("R4 legacy lanes, mask ignored", dst, {dold[127:32], el});
      if (c[0] && c[1] && !c[2]) begin
        if (c[3]) chk("R6 zeroed low lane", {96'h0, dst[31:0]}, '0);
        else      chk("R5 merged low lane", {96'h0, dst[31:0]}, {96'h0, 32'h3FC0_0000});
      end
    end

    // R7: flags suppressed on a masked-off lane, present otherwise
    three_op = 1'b1; men = 1'b1; mbit = 1'b0; mzero = 1'b0;
    src1 = {96'h0, 32'h3F80_0001}; src2 = {96'h0, 32'h3F80_0001};
    dold = {96'h0, 32'h1234_5678};
    step();
    chk("R7 masked flags", {123'h0, flags}, '0);
    mbit = 1'b1;
    step();
    chk("R7 unmasked flags", {123'h0, flags}, {123'h0, 5'h10});
    men = 1'b0; mbit = 1'b0;

    // R2: rounding source selection, RTZ gives ..02, RUP gives ..03
    src1 = {96'h0, 32'h3F80_0001}; src2 = {96'h0, 32'h3F80_0001};
    rmg = 2'b11; rms = 2'b10; rmsv = 1'b1; s2reg = 1'b1;
    step();
    chk("R2 override used", {96'h0, dst[31:0]}, {96'h0, 32'h3F80_0003});
    s2reg = 1'b0;
    step();
    chk("R2 memory source uses global", {96'h0, dst[31:0]}, {96'h0, 32'h3F80_0002});
    rmsv = 1'b0; s2reg = 1'b1;
    step();
    chk("R2 no override", {96'h0, dst[31:0]}, {96'h0, 32'h3F80_0002});

    // R8: special operands
    dir("R8 zero*inf", 32'h0000_0000, 32'h7F80_0000, 2'b00, 32'h7FC0_0000, 5'h01);
    dir("R8 snan quieted", 32'h7F80_0001, 32'h3F80_0000, 2'b00, 32'h7FC0_0001, 5'h01);
    dir("R8 qnan passes", 32'h3F80_0000, 32'hFFC0_0005, 2'b00, 32'hFFC0_0005, 5'h00);
    dir("R8 first nan wins", 32'h7FC0_0011, 32'h7F80_0002, 2'b00, 32'h7FC0_0011, 5'h01);
    dir("R8 signed zero", 32'h8000_0000, 32'h4000_0000, 2'b00, 32'h8000_0000, 5'h00);
    dir("R8 signed inf", 32'hFF80_0000, 32'h4000_0000, 2'b00, 32'hFF80_0000, 5'h00);

    // R9: overflow saturation by mode and sign
    dir("R9 ovf near", 32'h7F00_0000, 32'h4000_0000, 2'b00, 32'h7F80_0000, 5'h14);
    dir("R9 ovf zero", 32'h7F00_0000, 32'h4000_0000, 2'b11, 32'h7F7F_FFFF, 5'h14);
    dir("R9 ovf down pos", 32'h7F00_0000, 32'h4000_0000, 2'b01, 32'h7F7F_FFFF, 5'h14);
    dir("R9 ovf up pos", 32'h7F00_0000, 32'h4000_0000, 2'b10, 32'h7F80_0000, 5'h14);
    dir("R9 ovf down neg", 32'hFF00_0000, 32'h4000_0000, 2'b01, 32'hFF80_0000, 5'h14);
    dir("R9 ovf up neg", 32'hFF00_0000, 32'h4000_0000, 2'b10, 32'hFF7F_FFFF, 5'h14);

    // R10: denormal operand
    dir("R10 denormal input", 32'h0000_0001, 32'h4B00_0000, 2'b00, 32'h0080_0000, 5'h02);

    // R11: tiny results
    dir("R11 tiny exact", 32'h0080_0000, 32'h3F00_0000, 2'b00, 32'h0040_0000, 5'h00);
    dir("R11 tie to even", 32'h0080_0001, 32'h3F00_0000, 2'b00, 32'h0040_0000, 5'h18);
    dir("R11 tie up", 32'h0080_0001, 32'h3F00_0000, 2'b10, 32'h0040_0001, 5'h18);
    dir("R11 far below near", 32'h0080_0000, 32'h0080_0000, 2'b00, 32'h0000_0000, 5'h18);
    dir("R11 far below up", 32'h0080_0000, 32'h0080_0000, 2'b10, 32'h0000_0001, 5'h18);
    dir("R11 round into normal", 32'h00FF_FFFF, 32'h3F00_0000, 2'b00, 32'h0080_0000, 5'h18);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule